// File: doc/BRIEF.md
# OTP Controller Command Front-End

This block is the register-mapped command stage that sits between a software bus and the fuse-programming machinery of a one-time-programmable memory. It keeps one control word that software can reach in three ways. A plain write replaces the writable fields. A set alias ORs bits into them. A clear alias removes bits from them. The control word carries a target word address, a busy flag, a sticky error flag, a reload-in-progress flag and a 16-bit unlock key field.

A program operation is armed by placing the unlock key and the target address in the control word. Software then writes the data word. If the key matches and the target word is not locked, the block copies the address and the data into private registers and clears the key. It sets busy and sends a one-cycle start pulse to the fuse sequencer. If the target word is locked, no fuse access takes place and the sticky error flag rises. The error must be cleared through the clear alias before any new program or reload is accepted. A shadow reload is requested through its own control bit and handshaked with the shadow bank in the same way.

Top module: `otp_cmd_frontend`

## Requirements
- R1: After reset the control view reads 0x00000000, and progStart and reloadStart are low.
- R2: A write at offset 0x00 loads the address field (view bits [7:0]) and the key field (view bits [31:16]). Bits 8 (busy), 9 (error) and 10 (reload) of the view are not changed by the written value.
- R3: A write at offset 0x04 ORs the written address and key bits into those fields. A write at offset 0x08 clears every address and key bit that is 1 in the written value. Neither alias changes busy.
- R4: A data write (offset 0x20) accepted while idle, with key 0x3E77 present and an unlocked target word, gives the following one cycle later: progStart high for exactly one cycle, busy (bit 8) set, the key field cleared, progAddr equal to the address field and progData equal to the written word.
- R5: Busy stays set until a progDone pulse. It is low in the cycle after that pulse.
- R6: While busy, a data write is ignored: progData is unchanged and no start pulse follows. Address-field writes still update the view, but progAddr keeps the latched address.
- R7: A data write made when the key field is not 0x3E77 is ignored. Busy stays low, no start pulse follows and progData is unchanged.
- R8: A keyed data write to a word whose lockMap bit is 1 produces no start pulse and leaves busy low. It sets error (bit 9) and clears the key field.
- R9: Error is sticky. A plain write or a set-alias write never clears it. Only a clear-alias write with bit 9 = 1 clears it.
- R10: While error is set, keyed data writes and reload requests are ignored, and no start pulse of either kind follows.
- R11: Writing 1 to bit 10 through offset 0x00 or 0x04 while idle and error-free gives a one-cycle reloadStart pulse, and view bit 10 is set until a reloadDone pulse. While reload or busy is set, new data writes and reload requests are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe, one cycle per write |
| busOffset | input | 8 | Byte offset of the write |
| busWdata | input | 32 | Write data |
| ctrlView | output | 32 | Current control word: key [31:16], reload 10, error 9, busy 8, address [7:0] |
| lockMap | input | 256 | One lock bit per fuse word, indexed by word address |
| progStart | output | 1 | One-cycle start pulse to the fuse sequencer |
| progAddr | output | 8 | Word address latched when the program was accepted |
| progData | output | 32 | Data word latched when the program was accepted |
| progDone | input | 1 | Sequencer completion pulse |
| reloadStart | output | 1 | One-cycle start pulse to the shadow bank |
| reloadDone | input | 1 | Shadow reload completion pulse |

## Verification
The bench builds the block with its default parameters: an 8-bit word address over 256 words and a 32-bit data word. With these values every view bit position the requirements name exists, and the full address field can be driven through all three aliases. Word 0x55 is marked locked in the lock map, so the refusal path and its sticky error sit beside unlocked programs to 0x42 and 0x10. Completion pulses are driven by hand, so the bench can probe address and data writes while busy or reloading.

// File: rtl/otp_fe_pkg.sv
package otp_fe_pkg;

  // Byte offsets decoded on the register port
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_SET  = 8'h04;
  localparam logic [7:0] OFF_CLR  = 8'h08;
  localparam logic [7:0] OFF_DATA = 8'h20;

  // Bit positions inside the control word
  localparam int BUSY_BIT   = 8;
  localparam int ERR_BIT    = 9;
  localparam int RELOAD_BIT = 10;
  localparam int KEY_LSB    = 16;
  localparam int KEY_W      = 16;
  localparam int ADDR_MAX_W = 8;

  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'h3E77;

  // How the address and key fields react to the current bus write
  typedef enum logic [1:0] {
    FOP_HOLD  = 2'd0,
    FOP_LOAD  = 2'd1,
    FOP_SET   = 2'd2,
    FOP_CLEAR = 2'd3
  } fieldOp_e;

  // Strobes from control to datapath
  typedef struct packed {
    fieldOp_e fieldOp;
    logic     captureProg;  // latch address/data, consume key
    logic     consumeKey;   // refused request, consume key only
  } dpStrobe_t;

endpackage

// File: rtl/otp_fe_ctrl.sv
module otp_fe_ctrl
  import otp_fe_pkg::*;
#(
  parameter int OFF_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [OFF_W-1:0]  busOffset,
  input  logic [WORD_W-1:0] busWdata,
  input  logic              keyMatch,
  input  logic              lockHit,
  input  logic              progDone,
  input  logic              reloadDone,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              errFlag,
  output logic              reloadFlag,
  output logic              progStart,
  output logic              reloadStart
);

  logic isCtrl, isSet, isClr, isData;
  logic engaged;
  logic progReq, acceptProg, refuseProg;
  logic reloadReq, errClr;

  always_comb begin
    isCtrl = busWr && (busOffset == OFF_W'(OFF_CTRL));
    isSet  = busWr && (busOffset == OFF_W'(OFF_SET));
    isClr  = busWr && (busOffset == OFF_W'(OFF_CLR));
    isData = busWr && (busOffset == OFF_W'(OFF_DATA));

    // Any operation in flight blocks a new one
    engaged = busy || reloadFlag;

    progReq    = isData && !engaged && !errFlag && keyMatch;
    acceptProg = progReq && !lockHit;
    refuseProg = progReq && lockHit;

    reloadReq = (isCtrl || isSet) && busWdata[RELOAD_BIT] && !engaged && !errFlag;
    errClr    = isClr && busWdata[ERR_BIT];

    strobe.captureProg = acceptProg;
    strobe.consumeKey  = refuseProg;
    if (isCtrl)      strobe.fieldOp = FOP_LOAD;
    else if (isSet)  strobe.fieldOp = FOP_SET;
    else if (isClr)  strobe.fieldOp = FOP_CLEAR;
    else             strobe.fieldOp = FOP_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy        <= 1'b0;
      errFlag     <= 1'b0;
      reloadFlag  <= 1'b0;
      progStart   <= 1'b0;
      reloadStart <= 1'b0;
    end else begin
      progStart   <= acceptProg;
      reloadStart <= reloadReq;

      if (acceptProg)    busy <= 1'b1;
      else if (progDone) busy <= 1'b0;

      if (refuseProg)  errFlag <= 1'b1;
      else if (errClr) errFlag <= 1'b0;

      if (reloadReq)       reloadFlag <= 1'b1;
      else if (reloadDone) reloadFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/otp_fe_datapath.sv
module otp_fe_datapath
  import otp_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] busWdata,
  output logic [ADDR_W-1:0] addrField,
  output logic [KEY_W-1:0]  keyField,
  output logic              keyMatch,
  output logic [ADDR_W-1:0] progAddr,
  output logic [WORD_W-1:0] progData
);

  logic [ADDR_W-1:0] wAddr;
  logic [KEY_W-1:0]  wKey;
  logic [ADDR_W-1:0] addrNext;
  logic [KEY_W-1:0]  keyNext;

  always_comb begin
    wAddr = busWdata[ADDR_W-1:0];
    wKey  = busWdata[KEY_LSB +: KEY_W];
    unique case (strobe.fieldOp)
      FOP_LOAD:  begin addrNext = wAddr;              keyNext = wKey;             end
      FOP_SET:   begin addrNext = addrField | wAddr;  keyNext = keyField | wKey;  end
      FOP_CLEAR: begin addrNext = addrField & ~wAddr; keyNext = keyField & ~wKey; end
      default:   begin addrNext = addrField;          keyNext = keyField;         end
    endcase
    // Key is single use: gone once a request has consumed it
    if (strobe.captureProg || strobe.consumeKey) keyNext = '0;
    keyMatch = (keyField == UNLOCK_KEY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrField <= '0;
      keyField  <= '0;
      progAddr  <= '0;
      progData  <= '0;
    end else begin
      addrField <= addrNext;
      keyField  <= keyNext;
      if (strobe.captureProg) begin
        progAddr <= addrField;
        progData <= busWdata;
      end
    end
  end

endmodule

// File: rtl/otp_cmd_frontend.sv
module otp_cmd_frontend
  import otp_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 8,
  parameter int WORD_W = 32,
  localparam int WORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [OFF_W-1:0]  busOffset,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] ctrlView,
  input  logic [WORDS-1:0]  lockMap,
  output logic              progStart,
  output logic [ADDR_W-1:0] progAddr,
  output logic [WORD_W-1:0] progData,
  input  logic              progDone,
  output logic              reloadStart,
  input  logic              reloadDone
);

  // The address field must fit below the busy bit and the key above bit 15
  if (ADDR_W > ADDR_MAX_W || WORD_W < KEY_LSB + KEY_W) begin : g_badParam
    $error("otp_cmd_frontend: ADDR_W or WORD_W out of range");
  end

  dpStrobe_t         strobe;
  logic              busy, errFlag, reloadFlag;
  logic [ADDR_W-1:0] addrField;
  logic [KEY_W-1:0]  keyField;
  logic              keyMatch;
  logic              lockHit;

  assign lockHit = lockMap[addrField];

  otp_fe_ctrl #(
    .OFF_W (OFF_W),
    .WORD_W(WORD_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWr      (busWr),
    .busOffset  (busOffset),
    .busWdata   (busWdata),
    .keyMatch   (keyMatch),
    .lockHit    (lockHit),
    .progDone   (progDone),
    .reloadDone (reloadDone),
    .strobe     (strobe),
    .busy       (busy),
    .errFlag    (errFlag),
    .reloadFlag (reloadFlag),
    .progStart  (progStart),
    .reloadStart(reloadStart)
  );

  otp_fe_datapath #(
    .ADDR_W(ADDR_W),
    .WORD_W(WORD_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .busWdata (busWdata),
    .addrField(addrField),
    .keyField (keyField),
    .keyMatch (keyMatch),
    .progAddr (progAddr),
    .progData (progData)
  );

  always_comb begin
    ctrlView                      = '0;
    ctrlView[ADDR_W-1:0]          = addrField;
    ctrlView[BUSY_BIT]            = busy;
    ctrlView[ERR_BIT]             = errFlag;
    ctrlView[RELOAD_BIT]          = reloadFlag;
    ctrlView[KEY_LSB +: KEY_W]    = keyField;
  end

endmodule

// File: rtl/otp_fe_checker.sv
module otp_fe_checker
  import otp_fe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 8,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [OFF_W-1:0]  busOffset,
  input logic [WORD_W-1:0] busWdata,
  input logic [WORD_W-1:0] ctrlView,
  input logic              progStart,
  input logic [ADDR_W-1:0] progAddr,
  input logic [WORD_W-1:0] progData,
  input logic              reloadStart
);

  a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rstN)
    progStart |-> ctrlView[BUSY_BIT] && (ctrlView[KEY_LSB +: KEY_W] == '0));

  a_r4_start_single: assert property (@(posedge clk) disable iff (!rstN)
    progStart |=> !progStart);

  a_r6_addr_held: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlView[BUSY_BIT] && !progStart) |-> $stable(progAddr));

  a_r6_data_held: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlView[BUSY_BIT] && !progStart) |-> $stable(progData));

  a_r8_refuse_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlView[ERR_BIT]) |-> !progStart && !ctrlView[BUSY_BIT]);

  a_r9_err_clear_path: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ctrlView[ERR_BIT]) |->
      $past(busWr && busOffset == OFF_W'(OFF_CLR) && busWdata[ERR_BIT]));

  a_r10_err_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlView[ERR_BIT] && busWr) |=> !progStart && !reloadStart);

  a_r11_reload_flag: assert property (@(posedge clk) disable iff (!rstN)
    reloadStart |-> ctrlView[RELOAD_BIT] && !ctrlView[BUSY_BIT]);

endmodule

bind otp_cmd_frontend otp_fe_checker #(
  .ADDR_W(ADDR_W),
  .OFF_W (OFF_W),
  .WORD_W(WORD_W)
) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .busWr      (busWr),
  .busOffset  (busOffset),
  .busWdata   (busWdata),
  .ctrlView   (ctrlView),
  .progStart  (progStart),
  .progAddr   (progAddr),
  .progData   (progData),
  .reloadStart(reloadStart)
);

// File: tb/tb_otp_cmd_frontend.sv
`timescale 1ns/1ps
module tb_otp_cmd_frontend;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busWr = 1'b0;
  logic [7:0]   busOffset = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  ctrlView;
  logic [255:0] lockMap;
  logic         progStart;
  logic [7:0]   progAddr;
  logic [31:0]  progData;
  logic         progDone = 1'b0;
  logic         reloadStart;
  logic         reloadDone = 1'b0;

  int nCmp = 0;
  int nBad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  otp_cmd_frontend dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busOffset(busOffset),
    .busWdata(busWdata), .ctrlView(ctrlView), .lockMap(lockMap),
    .progStart(progStart), .progAddr(progAddr), .progData(progData),
    .progDone(progDone), .reloadStart(reloadStart), .reloadDone(reloadDone)
  );

  // {offset, write data, expected view after the write}
  localparam logic [71:0] VEC [0:6] = '{
    {8'h00, 32'h3E77_0012, 32'h3E77_0012},  // R2 plain load
    {8'h04, 32'h0000_0021, 32'h3E77_0033},  // R3 set alias
    {8'h08, 32'h3E00_0003, 32'h0077_0030},  // R3 clear alias
    {8'h00, 32'h0000_00A5, 32'h0000_00A5},  // R2 plain load
    {8'h04, 32'h3E77_0000, 32'h3E77_00A5},  // R3 set key
    {8'h08, 32'hFFFF_04FF, 32'h0000_0000},  // R3 clear all
    {8'h00, 32'h1234_0300, 32'h1234_0000}   // R2 busy/error not writable
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] off, input logic [31:0] data);
    @(negedge clk);
    busWr = 1'b1; busOffset = off; busWdata = data;
    @(negedge clk);
    busWr = 1'b0; busOffset = '0; busWdata = '0;
  endtask

  task automatic pulseDone(input bit isReload);
    @(negedge clk);
    if (isReload) reloadDone = 1'b1; else progDone = 1'b1;
    @(negedge clk);
    reloadDone = 1'b0; progDone = 1'b0;
  endtask

  initial begin
    lockMap = '0;
    lockMap[8'h55] = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 view", ctrlView, 32'h0);
    check("R1 progStart", {31'b0, progStart}, 32'h0);
    check("R1 reloadStart", {31'b0, reloadStart}, 32'h0);
    rstN = 1'b1;

    for (int i = 0; i < 7; i++) begin
      busWrite(VEC[i][71:64], VEC[i][63:32]);
      check("R2/R3 vector", ctrlView, VEC[i][31:0]);
      check("R2/R3 no start", {30'b0, progStart, reloadStart}, 32'h0);
    end

    // R4 accepted program
    busWrite(8'h00, 32'h3E77_0042);
    busWrite(8'h20, 32'hCAFE_0001);
    check("R4 start pulse", {31'b0, progStart}, 32'h1);
    check("R4 view busy key cleared", ctrlView, 32'h0000_0142);
    check("R4 progAddr", {24'b0, progAddr}, 32'h42);
    check("R4 progData", progData, 32'hCAFE_0001);
    @(negedge clk);
    check("R4 pulse one cycle", {31'b0, progStart}, 32'h0);

    // R6 writes while busy
    busWrite(8'h00, 32'h3E77_0011);
    check("R6 view updates", ctrlView, 32'h3E77_0111);
    check("R6 progAddr held", {24'b0, progAddr}, 32'h42);
    busWrite(8'h20, 32'h0000_1111);
    check("R6 data ignored", progData, 32'hCAFE_0001);
    check("R6 no start", {31'b0, progStart}, 32'h0);
    check("R6 key kept", ctrlView, 32'h3E77_0111);

    // R5 completion
    pulseDone(1'b0);
    check("R5 busy cleared", ctrlView, 32'h3E77_0011);

    // R7 no key
    busWrite(8'h08, 32'hFFFF_0000);
    busWrite(8'h20, 32'h0000_0005);
    check("R7 no start", {31'b0, progStart}, 32'h0);
    check("R7 view", ctrlView, 32'h0000_0011);
    check("R7 data unchanged", progData, 32'hCAFE_0001);

    // R8 locked word
    busWrite(8'h00, 32'h3E77_0055);
    busWrite(8'h20, 32'h0000_0007);
    check("R8 no start", {31'b0, progStart}, 32'h0);
    check("R8 error set key cleared", ctrlView, 32'h0000_0255);
    check("R8 data unchanged", progData, 32'hCAFE_0001);

    // R9 sticky error
    busWrite(8'h00, 32'h0000_0055);
    check("R9 plain keeps error", ctrlView, 32'h0000_0255);
    busWrite(8'h04, 32'h0000_0200);
    check("R9 set keeps error", ctrlView, 32'h0000_0255);

    // R10 error blocks program and reload
    busWrite(8'h00, 32'h3E77_0010);
    busWrite(8'h20, 32'h0000_0009);
    check("R10 program blocked", {30'b0, progStart, reloadStart}, 32'h0);
    check("R10 view", ctrlView, 32'h3E77_0210);
    busWrite(8'h04, 32'h0000_0400);
    check("R10 reload blocked", {30'b0, progStart, reloadStart}, 32'h0);
    check("R10 view after reload req", ctrlView, 32'h3E77_0210);

    busWrite(8'h08, 32'h0000_0200);
    check("R9 clear alias clears error", ctrlView, 32'h3E77_0010);

    busWrite(8'h20, 32'h0000_0009);
    check("R4 start after clear", {31'b0, progStart}, 32'h1);
    check("R4 progAddr 0x10", {24'b0, progAddr}, 32'h10);
    // R11 reload refused while busy
    busWrite(8'h04, 32'h0000_0400);
    check("R11 reload blocked by busy", {31'b0, reloadStart}, 32'h0);
    check("R11 view busy only", ctrlView, 32'h0000_0110);
    pulseDone(1'b0);

    // R11 reload
    busWrite(8'h04, 32'h0000_0400);
    check("R11 reload pulse", {31'b0, reloadStart}, 32'h1);
    check("R11 reload flag", ctrlView, 32'h0000_0410);
    @(negedge clk);
    check("R11 reload pulse one cycle", {31'b0, reloadStart}, 32'h0);
    busWrite(8'h04, 32'h3E77_0000);
    busWrite(8'h20, 32'h0000_000A);
    check("R11 data blocked during reload", {31'b0, progStart}, 32'h0);
    check("R11 data unchanged", progData, 32'h0000_0009);
    pulseDone(1'b1);
    check("R11 reload done", ctrlView, 32'h3E77_0010);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule